// File: doc/BRIEF.md
# Hybrid-Rail Dual-Bit Ripple Adder

The block adds two 32-bit operands and a carry-in. Every operand bit and every carry travels as a pair of wires. For a pair written (true rail, false rail), 10 means logic 1, 01 means logic 0, 00 means empty, and 11 is illegal. The adder is a ripple chain of sixteen cells, and each cell handles two bit positions. A cell passes a dual-rail carry to the next cell and presents its two sum bits on single wires. Since a sum bit carries no validity of its own, a sum bit counts as valid only once its own cell's carry pair holds a legal value.

One request line reaches every cell. While request is low, every output is empty: all sums read 0 and every carry pair reads 00. When request rises, all cells arm together. A cell evaluates once its operand pairs and its incoming carry pair are all legal, and the carry-in is always the last of these to arrive. The model gives each cell one clock cycle from carry-in to carry-out, so the complete carry walk takes sixteen cycles.

Completion is read only from the last carry pair. The done output serves as the acknowledge of a four-phase exchange:
- raise request with valid operands;
- wait for done;
- lower request and empty the operands;
- done then falls.

Top module: `hybrid_rail_adder`

## Requirements
- R1: While reset is applied and right after it, the sum reads 0, the carry-out pair reads 00 and done reads 0.
- R2: In the same cycle that request is low, the sum reads 0, the carry-out pair reads 00 and done reads 0. Lowering request for one clock edge clears every cell.
- R3: Request is raised with legal operand and carry-in pairs, which are then held. Done asserts exactly after the 16th rising edge that sees request high, and never earlier.
- R4: When done is high, the sum equals the low 32 bits of a + b + cin, where each value is taken from the true rails.
- R5: When done is high, the carry-out pair reads 10 for a carry of 1 and 01 for a carry of 0.
- R6: After done, while request stays high with the same inputs, the sum, the carry-out pair and done hold their values.
- R7: A cell whose operand pairs are not all legal (00 or 11) does not evaluate. Neither it nor any cell above it produces a sum or carry, and done stays low. Once the pair becomes legal, the rest of the chain completes at one cell per edge.
- R8: Cell k covers sum bits 2k and 2k+1. After n edges with request high, those bits read 0 for every cell k ≥ n and read the correct value for every cell k < n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Shared request: low empties all cells, high lets them evaluate |
| a_t | input | 32 | Operand A, true rails |
| a_f | input | 32 | Operand A, false rails |
| b_t | input | 32 | Operand B, true rails |
| b_f | input | 32 | Operand B, false rails |
| cin_t | input | 1 | Carry-in, true rail |
| cin_f | input | 1 | Carry-in, false rail |
| sum | output | 32 | Single-rail sum, 0 while empty |
| cout_t | output | 1 | Final carry-out, true rail |
| cout_f | output | 1 | Final carry-out, false rail |
| done | output | 1 | Completion / acknowledge, taken from the final carry pair |

## Verification
Counting from the edge that first sees request high, the bits of cell k are due after edge k+1, and done and the final carry are due after edge 16. The bench samples at each falling edge after edges 1 through 16. At each sample it compares the sum against the reference masked to the cells already due, and checks that done is still low before edge 16. The empty state after request falls is sampled one time step later in the same cycle, because request gates the outputs directly. In the stall case, a pair is restored after edge 20, and done is expected exactly six edges later.

// File: rtl/hra_pkg.sv
package hra_pkg;
  // a rail pair holds a legal codeword when exactly one rail is high
  function automatic logic pair_ok(input logic t, input logic f);
    return t ^ f;
  endfunction

  function automatic logic pairs_ok(input logic [1:0] t, input logic [1:0] f);
    return &(t ^ f);
  endfunction
endpackage

// File: rtl/hra_cell.sv
module hra_cell
  import hra_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [LANES-1:0] a_t,
  input  logic [LANES-1:0] a_f,
  input  logic [LANES-1:0] b_t,
  input  logic [LANES-1:0] b_f,
  input  logic             ci_t,
  input  logic             ci_f,
  output logic [LANES-1:0] s,
  output logic             co_t,
  output logic             co_f
);
  localparam int TW = LANES + 1;

  logic [LANES-1:0] s_q, s_d;
  logic             cot_q, cot_d, cof_q, cof_d;
  logic             ops_ok, ci_ok, co_empty, fire, en;
  logic [TW-1:0]    total;

  assign ops_ok   = &(a_t ^ a_f) & &(b_t ^ b_f);
  assign ci_ok    = pair_ok(ci_t, ci_f);
  assign co_empty = !(cot_q | cof_q);
  assign fire     = req & ops_ok & ci_ok & co_empty;
  assign en       = !req | fire;
  assign total    = TW'(a_t) + TW'(b_t) + TW'(ci_t);

  always_comb begin
    s_d   = s_q;
    cot_d = cot_q;
    cof_d = cof_q;
    if (!req) begin
      s_d   = '0;
      cot_d = 1'b0;
      cof_d = 1'b0;
    end else if (fire) begin
      s_d   = total[LANES-1:0];
      cot_d = total[LANES];
      cof_d = !total[LANES];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q   <= '0;
      cot_q <= 1'b0;
      cof_q <= 1'b0;
    end else if (en) begin
      s_q   <= s_d;
      cot_q <= cot_d;
      cof_q <= cof_d;
    end
  end

  // request gates every output so the empty state shows in the same cycle
  assign s    = s_q & {LANES{req}};
  assign co_t = cot_q & req;
  assign co_f = cof_q & req;

  // R2
  req_low_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (!cot_q && !cof_q && s_q == '0));

  // R6
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !co_empty) |=> (!req || $stable({cot_q, cof_q, s_q})));

  // R8
  sum_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    co_empty |-> (s_q == '0));

  // R5
  carry_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cot_q && cof_q));

  // R7
  carry_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !co_empty) |-> (ci_ok && ops_ok));
endmodule

// File: rtl/hra_done.sv
module hra_done
  import hra_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic last_t,
  input  logic last_f,
  output logic done
);
  assign done = pair_ok(last_t, last_f);

  // R2
  done_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req);
endmodule

// File: rtl/hybrid_rail_adder.sv
module hybrid_rail_adder
  import hra_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [WIDTH-1:0] a_t,
  input  logic [WIDTH-1:0] a_f,
  input  logic [WIDTH-1:0] b_t,
  input  logic [WIDTH-1:0] b_f,
  input  logic             cin_t,
  input  logic             cin_f,
  output logic [WIDTH-1:0] sum,
  output logic             cout_t,
  output logic             cout_f,
  output logic             done
);
  localparam int NCELL = WIDTH / LANES;

  logic [NCELL:0]   ct, cf;
  logic [NCELL-1:0] cell_ok;

  assign ct[0] = cin_t;
  assign cf[0] = cin_f;

  for (genvar k = 0; k < NCELL; k++) begin : g_cell
    hra_cell #(.LANES(LANES)) u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (req),
      .a_t  (a_t[k*LANES +: LANES]),
      .a_f  (a_f[k*LANES +: LANES]),
      .b_t  (b_t[k*LANES +: LANES]),
      .b_f  (b_f[k*LANES +: LANES]),
      .ci_t (ct[k]),
      .ci_f (cf[k]),
      .s    (sum[k*LANES +: LANES]),
      .co_t (ct[k+1]),
      .co_f (cf[k+1])
    );
    assign cell_ok[k] = pair_ok(ct[k+1], cf[k+1]);
  end

  assign cout_t = ct[NCELL];
  assign cout_f = cf[NCELL];

  hra_done u_done (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .last_t(ct[NCELL]),
    .last_f(cf[NCELL]),
    .done  (done)
  );

  // R3
  done_after_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (&cell_ok));

  // R1
  reset_empty_chk: assert property (@(posedge clk)
    !rst_n |-> (!done && sum == '0));
endmodule

// File: tb/hybrid_rail_adder_tb.sv
module hybrid_rail_adder_tb;
  localparam int W = 32;
  localparam int NC = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req;
  logic [W-1:0] a_t, a_f, b_t, b_f, sum;
  logic         cin_t, cin_f, cout_t, cout_f, done;
  int           tests = 0;
  int           fails = 0;
  bit           ended = 1'b0;

  always #4 clk = ~clk;

  hybrid_rail_adder u_dut (
    .clk(clk), .rst_n(rst_n), .req(req),
    .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
    .cin_t(cin_t), .cin_f(cin_f),
    .sum(sum), .cout_t(cout_t), .cout_f(cout_f), .done(done)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_ops(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    a_t = a; a_f = ~a; b_t = b; b_f = ~b; cin_t = c; cin_f = ~c;
  endtask

  task automatic empty_ops();
    a_t = '0; a_f = '0; b_t = '0; b_f = '0; cin_t = 1'b0; cin_f = 1'b0;
  endtask

  task automatic finish_op();
    @(negedge clk);
    req = 1'b0;
    empty_ops();
    #1;
    check(sum == 0 && {cout_t, cout_f} == 2'b00 && !done, "R2",
          {sum, 29'd0, cout_t, cout_f, done}, 64'd0);
    @(negedge clk);
  endtask

  task automatic run_vec(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    logic [W:0]   exp;
    logic [W-1:0] mask;
    exp = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    @(negedge clk);
    set_ops(a, b, c);
    req = 1'b1;
    for (int n = 1; n <= NC; n++) begin
      @(posedge clk);
      @(negedge clk);
      mask = (n >= NC) ? '1 : ((32'h1 << (2 * n)) - 32'h1);
      check(sum == (exp[W-1:0] & mask), "R8", sum, exp[W-1:0] & mask);
      check(done == (n == NC), "R3", done, (n == NC));
    end
    check(sum == exp[W-1:0], "R4", sum, exp[W-1:0]);
    check({cout_t, cout_f} == {exp[W], ~exp[W]}, "R5", {cout_t, cout_f}, {exp[W], ~exp[W]});
    @(posedge clk);
    @(negedge clk);
    check(sum == exp[W-1:0] && done && cout_t == exp[W], "R6",
          {sum, done}, {exp[W-1:0], 1'b1});
    finish_op();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req   = 1'b0;
    empty_ops();
    repeat (3) @(negedge clk);
    // R1 during reset
    check(sum == 0 && !done && {cout_t, cout_f} == 2'b00, "R1", {sum, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sum == 0 && !done, "R1", {sum, done}, 64'd0);

    run_vec(32'h0, 32'h0, 1'b0);
    run_vec(32'hFFFF_FFFF, 32'h0, 1'b1);
    run_vec(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    run_vec(32'h5555_5555, 32'hAAAA_AAAA, 1'b0);
    run_vec(32'h5555_5555, 32'hAAAA_AAAA, 1'b1);
    run_vec(32'h8000_0000, 32'h8000_0000, 1'b0);
    for (int i = 0; i < 40; i++)
      run_vec($urandom, $urandom, 1'($urandom));

    // R7: empty operand pair at bit 20 (cell 10) stalls the chain
    begin
      logic [W:0] exp;
      exp = {1'b0, 32'h1234_5678} + {1'b0, 32'h0FED_CBA9} + 33'd1;
      @(negedge clk);
      set_ops(32'h1234_5678, 32'h0FED_CBA9, 1'b1);
      b_t[20] = 1'b0; b_f[20] = 1'b0;
      req = 1'b1;
      repeat (20) @(posedge clk);
      @(negedge clk);
      check(!done, "R7", done, 0);
      check(sum == (exp[W-1:0] & 32'h000F_FFFF), "R7", sum, exp[W-1:0] & 32'h000F_FFFF);
      b_t[20] = 1'b0; b_f[20] = 1'b1;   // 0x0FEDCBA9 has bit 20 clear
      for (int n = 1; n <= 6; n++) begin
        @(posedge clk);
        @(negedge clk);
        check(done == (n == 6), "R7", done, (n == 6));
      end
      check(sum == exp[W-1:0], "R7", sum, exp[W-1:0]);
      finish_op();
    end

    // R7: illegal 11 pair at bit 3 (cell 1) blocks cell 1 and above
    @(negedge clk);
    set_ops(32'h0000_0003, 32'h0000_0001, 1'b0);
    a_f[3] = 1'b1; a_t[3] = 1'b1;
    req = 1'b1;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(!done && sum == 32'h0000_0000, "R7", {sum, done}, 64'd0);
    finish_op();

    run_vec(32'h7FFF_FFFF, 32'h0000_0001, 1'b0);

    ended = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule